// File: doc/BRIEF.md
# Tagged Receive FIFO with Idle Timeout

This block sits between a serial deserializer and a host read port. Each character that the deserializer delivers is stored together with three error tags: parity, framing and break. The host sees the oldest character and its tags at all times. Popping that character brings the next one, with its own tags, to the port in the following cycle.

A data-ready interrupt is raised in one of two ways. In buffered mode it is raised when the fill count reaches a selectable trigger level. In single-character mode it is raised as soon as any character is present. A second interrupt covers characters that are stranded below the trigger level. An idle timer, clocked by a 16x sample enable, measures four character frames plus twelve bit times at the programmed word length. If nothing arrives and nothing is read in that window, the timeout interrupt is raised. A single enable masks both interrupts.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: After reset the queue is empty: `fill` is 0, `data_rdy` is 0, `overrun` is 0, `irq` is 0, and `head_data` and `stat_tags` read 0.
- R2: Characters leave in arrival order. `head_data` shows the oldest entry. `stat_tags` shows that entry's tags, with bit 0 for parity, bit 1 for framing and bit 2 for break. Each accepted write without a pop raises `fill` by one.
- R3: After a pop edge, the next entry's data and tags are on `head_data` and `stat_tags` in the very next cycle.
- R4: The queue holds 16 entries. A write while full, with no pop in the same cycle, is discarded and sets `overrun`. `overrun` stays set until a `stat_rd` pulse clears it.
- R5: A write and a pop in the same cycle while full are both performed. `fill` stays at 16 and the new character goes to the tail.
- R6: With `fifo_on`=1, `irq_trig` asserts when `fill` is at least the trigger level. `trig_sel` 00, 01, 10 and 11 select levels 1, 4, 8 and 14.
- R7: With `fifo_on`=0, `irq_trig` asserts whenever at least one character is held, whatever `trig_sel` is.
- R8: With `ie_data`=0, `irq`, `irq_trig` and `irq_tmo` stay 0.
- R9: `irq_tmo` asserts after 16*(4*(n+2)+12) consecutive `tick16` pulses without a write or a pop while the queue is non-empty. `word_len` 00, 01, 10 and 11 give n = 5, 6, 7 and 8, which is 640, 704, 768 and 832 ticks.
- R10: Any write or pop restarts the idle count and clears `irq_tmo`. `irq_tmo` never asserts while the queue is empty.
- R11: A pop on an empty queue has no effect: `fill` stays 0 and later writes are read back in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_vld | input | 1 | Deserializer delivers a character this cycle |
| wr_data | input | 8 | Received character |
| wr_par_err | input | 1 | Parity error tag of the character |
| wr_frm_err | input | 1 | Framing error tag of the character |
| wr_brk | input | 1 | Break tag of the character |
| rd_pop | input | 1 | Host consumes the head entry |
| stat_rd | input | 1 | Host reads status; clears overrun |
| tick16 | input | 1 | 16x sample-clock enable |
| word_len | input | 2 | Data bits per character: 5 + value |
| trig_sel | input | 2 | Trigger level select (1, 4, 8, 14) |
| fifo_on | input | 1 | 1: trigger-level mode, 0: single-character mode |
| ie_data | input | 1 | Receive-data interrupt enable |
| head_data | output | 8 | Oldest held character (0 when empty) |
| stat_tags | output | 3 | Tags of head entry: [0] parity, [1] framing, [2] break |
| data_rdy | output | 1 | At least one character held |
| overrun | output | 1 | Sticky: a character was lost to a full queue |
| fill | output | 5 | Number of held characters |
| irq_trig | output | 1 | Trigger-level / per-character interrupt |
| irq_tmo | output | 1 | Idle-timeout interrupt |
| irq | output | 1 | OR of both interrupts |

## Verification
Fill count, overrun and head entry are registered, so each write, pop or status read shows its effect one cycle after the edge that takes it in. The bench therefore samples one time unit after that edge. The interrupt outputs decode `fill` without further registers and move in the same cycle as `fill`. The timeout flag rises exactly on the tick that completes the window. With `tick16` held high, the bench counts edges from the last write: it expects the flag low after one edge fewer than the tick count and high after the full count. Restart behaviour is checked by writing again partway through the window and repeating that count.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   // Error tags carried beside each character; bit order matches stat_tags.
   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rxq_tags_t;

   // Smallest character length selected by word_len = 00.
   localparam int RXQ_MIN_BITS = 5;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DEPTH = 16,
   parameter int ENT_W = 11,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [ENT_W-1:0] wdata,
   output logic [ENT_W-1:0] rdata,
   output logic [CNT_W-1:0] cnt,
   output logic             empty,
   output logic             ovr_evt
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wp, rp, wp_nxt, rp_nxt;
   logic             do_pop, do_push, full;

   assign empty   = (cnt == '0);
   assign full    = (cnt == FULL_CNT);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign ovr_evt = push && full && !do_pop;

   // Pointer advance: free wrap for power-of-two depths, explicit wrap otherwise.
   generate
      if (POW2) begin : g_wrap_free
         assign wp_nxt = wp + 1'b1;
         assign rp_nxt = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nxt = (wp == LAST_PTR) ? '0 : wp + 1'b1;
         assign rp_nxt = (rp == LAST_PTR) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nxt;
         if (do_pop)  rp <= rp_nxt;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   assign rdata = mem[rp];

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
   parameter int SAMPLE    = 16,
   parameter int TMO_CHARS = 4,
   parameter int TMO_EXTRA = 12,
   parameter int FRAME_OVH = 2,
   parameter int MIN_BITS  = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       restart,
   input  logic       armed,
   input  logic [1:0] word_len,
   output logic       expired
);

   localparam int MAX_LIMIT = SAMPLE * (TMO_CHARS * (MIN_BITS + 3 + FRAME_OVH) + TMO_EXTRA);
   localparam int TW        = $clog2(MAX_LIMIT + 1);

   logic [TW-1:0] tick_cnt, limit;
   int            lim_int;

   always_comb begin
      lim_int = SAMPLE * (TMO_CHARS * (MIN_BITS + int'(word_len) + FRAME_OVH) + TMO_EXTRA);
      limit   = TW'(lim_int);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_cnt <= '0;
         expired  <= 1'b0;
      end else if (restart || !armed) begin
         tick_cnt <= '0;
         expired  <= 1'b0;
      end else if (tick && !expired) begin
         tick_cnt <= tick_cnt + 1'b1;
         if (tick_cnt + 1'b1 >= limit) expired <= 1'b1;
      end
   end

endmodule

// File: rtl/rxq_irq_ctl.sv
module rxq_irq_ctl #(
   parameter int DEPTH   = 16,
   parameter int TRIG_L0 = 1,
   parameter int TRIG_L1 = 4,
   parameter int TRIG_L2 = 8,
   parameter int TRIG_L3 = 14,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic [CNT_W-1:0] fill,
   input  logic [1:0]       trig_sel,
   input  logic             fifo_on,
   input  logic             ie_data,
   input  logic             tmo,
   output logic             irq_trig,
   output logic             irq_tmo,
   output logic             irq
);

   logic [CNT_W-1:0] lvl;

   always_comb begin
      unique case (trig_sel)
         2'b00:   lvl = CNT_W'(TRIG_L0);
         2'b01:   lvl = CNT_W'(TRIG_L1);
         2'b10:   lvl = CNT_W'(TRIG_L2);
         default: lvl = CNT_W'(TRIG_L3);
      endcase
      if (!fifo_on) lvl = CNT_W'(1);
   end

   assign irq_trig = ie_data && (fill >= lvl);
   assign irq_tmo  = ie_data && tmo;
   assign irq      = irq_trig || irq_tmo;

endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
   import rxq_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int DATA_W    = 8,
   parameter int TAG_W     = 3,
   parameter int SAMPLE    = 16,
   parameter int TMO_CHARS = 4,
   parameter int TMO_EXTRA = 12,
   parameter int FRAME_OVH = 2,
   parameter int TRIG_L0   = 1,
   parameter int TRIG_L1   = 4,
   parameter int TRIG_L2   = 8,
   parameter int TRIG_L3   = 14,
   localparam int FILL_W   = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_vld,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_par_err,
   input  logic              wr_frm_err,
   input  logic              wr_brk,
   input  logic              rd_pop,
   input  logic              stat_rd,
   input  logic              tick16,
   input  logic [1:0]        word_len,
   input  logic [1:0]        trig_sel,
   input  logic              fifo_on,
   input  logic              ie_data,
   output logic [DATA_W-1:0] head_data,
   output logic [TAG_W-1:0]  stat_tags,
   output logic              data_rdy,
   output logic              overrun,
   output logic [FILL_W-1:0] fill,
   output logic              irq_trig,
   output logic              irq_tmo,
   output logic              irq
);

   localparam int ENT_W = DATA_W + TAG_W;

   // Elaboration-time parameter checks.
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxq_tagged_fifo: DEPTH must be at least 2");
      end
      if (TAG_W != $bits(rxq_tags_t)) begin : g_bad_tags
         $error("rxq_tagged_fifo: TAG_W must match the tag struct");
      end
      if (TRIG_L0 < 1 || TRIG_L3 > DEPTH || TRIG_L0 > TRIG_L1 ||
          TRIG_L1 > TRIG_L2 || TRIG_L2 > TRIG_L3) begin : g_bad_trig
         $error("rxq_tagged_fifo: trigger levels must rise within 1..DEPTH");
      end
      if (SAMPLE < 1 || TMO_CHARS < 1) begin : g_bad_tmo
         $error("rxq_tagged_fifo: timeout parameters must be positive");
      end
   endgenerate

   rxq_tags_t        in_tags;
   logic [ENT_W-1:0] head_ent;
   logic             empty, ovr_evt, tmo_flag;

   assign in_tags = '{brk: wr_brk, frm: wr_frm_err, par: wr_par_err};

   rxq_store #(
      .DEPTH (DEPTH),
      .ENT_W (ENT_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (wr_vld),
      .pop     (rd_pop),
      .wdata   ({in_tags, wr_data}),
      .rdata   (head_ent),
      .cnt     (fill),
      .empty   (empty),
      .ovr_evt (ovr_evt)
   );

   rxq_idle_timer #(
      .SAMPLE    (SAMPLE),
      .TMO_CHARS (TMO_CHARS),
      .TMO_EXTRA (TMO_EXTRA),
      .FRAME_OVH (FRAME_OVH),
      .MIN_BITS  (RXQ_MIN_BITS)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick16),
      .restart  (wr_vld || rd_pop),
      .armed    (!empty),
      .word_len (word_len),
      .expired  (tmo_flag)
   );

   rxq_irq_ctl #(
      .DEPTH   (DEPTH),
      .TRIG_L0 (TRIG_L0),
      .TRIG_L1 (TRIG_L1),
      .TRIG_L2 (TRIG_L2),
      .TRIG_L3 (TRIG_L3)
   ) u_irq (
      .fill     (fill),
      .trig_sel (trig_sel),
      .fifo_on  (fifo_on),
      .ie_data  (ie_data),
      .tmo      (tmo_flag),
      .irq_trig (irq_trig),
      .irq_tmo  (irq_tmo),
      .irq      (irq)
   );

   // Sticky overrun: a new loss wins over a clearing status read.
   always_ff @(posedge clk) begin
      if (!rst_n)        overrun <= 1'b0;
      else if (ovr_evt)  overrun <= 1'b1;
      else if (stat_rd)  overrun <= 1'b0;
   end

   assign data_rdy  = !empty;
   assign head_data = empty ? '0 : head_ent[DATA_W-1:0];
   assign stat_tags = empty ? '0 : head_ent[ENT_W-1:DATA_W];

endmodule

// File: rtl/rxq_tagged_fifo_chk.sv
module rxq_tagged_fifo_chk #(
   parameter int DEPTH  = 16,
   localparam int FILL_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_vld,
   input logic              rd_pop,
   input logic              ie_data,
   input logic [FILL_W-1:0] fill,
   input logic              overrun,
   input logic              irq,
   input logic              irq_tmo
);

   localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

   assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL);

   assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == FULL && wr_vld && !rd_pop) |=> (fill == FULL && overrun));

   assert_fill_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && !rd_pop && fill != FULL) |=> fill == $past(fill) + 1'b1);

   assert_swap_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && rd_pop && fill == FULL) |=> fill == FULL);

   assert_masked_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_data |-> !irq);

   assert_empty_no_tmo_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fill == '0 |-> !irq_tmo);

   assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld || rd_pop) |=> !irq_tmo);

   assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == '0 && rd_pop && !wr_vld) |=> fill == '0);

endmodule

bind rxq_tagged_fifo rxq_tagged_fifo_chk #(.DEPTH(DEPTH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_vld  (wr_vld),
   .rd_pop  (rd_pop),
   .ie_data (ie_data),
   .fill    (fill),
   .overrun (overrun),
   .irq     (irq),
   .irq_tmo (irq_tmo)
);

// File: tb/rxq_tagged_fifo_test.sv
module rxq_tagged_fifo_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_vld, wr_par_err, wr_frm_err, wr_brk;
   logic [7:0] wr_data;
   logic       rd_pop, stat_rd, tick16, fifo_on, ie_data;
   logic [1:0] word_len, trig_sel;
   logic [7:0] head_data;
   logic [2:0] stat_tags;
   logic       data_rdy, overrun, irq_trig, irq_tmo, irq;
   logic [4:0] fill;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rxq_tagged_fifo uut (
      .clk (clk), .rst_n (rst_n),
      .wr_vld (wr_vld), .wr_data (wr_data), .wr_par_err (wr_par_err),
      .wr_frm_err (wr_frm_err), .wr_brk (wr_brk),
      .rd_pop (rd_pop), .stat_rd (stat_rd), .tick16 (tick16),
      .word_len (word_len), .trig_sel (trig_sel), .fifo_on (fifo_on),
      .ie_data (ie_data),
      .head_data (head_data), .stat_tags (stat_tags), .data_rdy (data_rdy),
      .overrun (overrun), .fill (fill), .irq_trig (irq_trig),
      .irq_tmo (irq_tmo), .irq (irq)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   // Advance one edge; sample one time unit after it.
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input logic [7:0] d, input logic [2:0] t);
      wr_vld = 1'b1; wr_data = d;
      wr_brk = t[2]; wr_frm_err = t[1]; wr_par_err = t[0];
      step();
      wr_vld = 1'b0; wr_brk = 1'b0; wr_frm_err = 1'b0; wr_par_err = 1'b0;
   endtask

   task automatic pop();
      rd_pop = 1'b1;
      step();
      rd_pop = 1'b0;
   endtask

   task automatic drain();
      while (fill != 0) pop();
   endtask

   function automatic int tmo_ticks(input int wl);
      return 16 * (4 * (5 + wl + 2) + 12);
   endfunction

   task automatic t_reset();
      chk("R1 fill", fill, 0);
      chk("R1 data_rdy", data_rdy, 0);
      chk("R1 overrun", overrun, 0);
      chk("R1 irq", irq, 0);
      chk("R1 head", {stat_tags, head_data}, 0);
   endtask

   task automatic t_order();
      push(8'hA5, 3'b001);
      chk("R2 fill after one", fill, 1);
      push(8'h3C, 3'b010);
      push(8'h7E, 3'b100);
      chk("R2 fill after three", fill, 3);
      chk("R2 head data", head_data, 8'hA5);
      chk("R2 head parity tag", stat_tags, 3'b001);
      pop();
      chk("R3 next data", head_data, 8'h3C);
      chk("R3 next framing tag", stat_tags, 3'b010);
      pop();
      chk("R3 third data", head_data, 8'h7E);
      chk("R3 third break tag", stat_tags, 3'b100);
      pop();
      chk("R3 empty after drain", data_rdy, 0);
   endtask

   task automatic t_full();
      for (int i = 0; i < 16; i++) push(8'(8'h10 + i), 3'(i));
      chk("R4 fill at capacity", fill, 16);
      chk("R4 no overrun yet", overrun, 0);
      push(8'hEE, 3'b111);
      chk("R4 fill after drop", fill, 16);
      chk("R4 overrun set", overrun, 1);
      chk("R4 head unchanged", head_data, 8'h10);
      stat_rd = 1'b1; step(); stat_rd = 1'b0;
      chk("R4 overrun cleared", overrun, 0);
      // R5: simultaneous write and pop while full
      wr_vld = 1'b1; wr_data = 8'h99; wr_brk = 1'b1; wr_frm_err = 1'b0; wr_par_err = 1'b1;
      rd_pop = 1'b1;
      step();
      wr_vld = 1'b0; rd_pop = 1'b0; wr_brk = 1'b0; wr_par_err = 1'b0;
      chk("R5 fill stays full", fill, 16);
      chk("R5 no overrun", overrun, 0);
      chk("R5 head advanced", head_data, 8'h11);
      for (int i = 0; i < 15; i++) pop();
      chk("R5 tail data", head_data, 8'h99);
      chk("R5 tail tags", stat_tags, 3'b101);
      pop();
      chk("R5 empty", fill, 0);
   endtask

   task automatic t_trig();
      int lv[4] = '{1, 4, 8, 14};
      fifo_on = 1'b1; ie_data = 1'b1;
      for (int s = 0; s < 4; s++) begin
         trig_sel = 2'(s);
         for (int i = 0; i < lv[s] - 1; i++) push(8'(i), 3'b000);
         chk($sformatf("R6 below level %0d", lv[s]), irq_trig, 0);
         push(8'h55, 3'b000);
         chk($sformatf("R6 at level %0d", lv[s]), irq_trig, 1);
         chk($sformatf("R6 irq at level %0d", lv[s]), irq, 1);
         drain();
      end
   endtask

   task automatic t_perchar();
      fifo_on = 1'b0; trig_sel = 2'b11; ie_data = 1'b1;
      chk("R7 idle no irq", irq_trig, 0);
      push(8'h42, 3'b000);
      chk("R7 irq on one char", irq_trig, 1);
      drain();
      chk("R7 cleared when empty", irq_trig, 0);
      fifo_on = 1'b1;
   endtask

   task automatic t_mask();
      ie_data = 1'b0; fifo_on = 1'b0;
      push(8'h01, 3'b000);
      chk("R8 masked trig", irq_trig, 0);
      chk("R8 masked irq", irq, 0);
      drain();
      ie_data = 1'b1; fifo_on = 1'b1;
   endtask

   task automatic t_empty_pop();
      pop();
      chk("R11 fill stays zero", fill, 0);
      chk("R11 no data ready", data_rdy, 0);
      push(8'hC3, 3'b010);
      push(8'hD4, 3'b000);
      chk("R11 order kept", head_data, 8'hC3);
      pop();
      chk("R11 second kept", head_data, 8'hD4);
      pop();
   endtask

   task automatic t_timeout(input int wl);
      int n = tmo_ticks(wl);
      word_len = 2'(wl); fifo_on = 1'b1; trig_sel = 2'b11; ie_data = 1'b1;
      tick16 = 1'b1;
      push(8'h20, 3'b000);
      for (int i = 0; i < n - 1; i++) step();
      chk($sformatf("R9 wl%0d one tick early", wl), irq_tmo, 0);
      step();
      chk($sformatf("R9 wl%0d at limit", wl), irq_tmo, 1);
      chk($sformatf("R9 wl%0d irq", wl), irq, 1);
      pop();
      chk("R10 pop clears timeout", irq_tmo, 0);
      tick16 = 1'b0;
   endtask

   task automatic t_restart();
      int n = tmo_ticks(0);
      word_len = 2'b00; tick16 = 1'b1;
      push(8'h30, 3'b000);
      for (int i = 0; i < n - 5; i++) step();
      push(8'h31, 3'b000);
      for (int i = 0; i < n - 1; i++) step();
      chk("R10 restart on write", irq_tmo, 0);
      step();
      chk("R10 fires after restart", irq_tmo, 1);
      drain();
      for (int i = 0; i < n + 5; i++) step();
      chk("R10 silent when empty", irq_tmo, 0);
      tick16 = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; wr_vld = 1'b0; wr_data = '0; wr_par_err = 1'b0;
      wr_frm_err = 1'b0; wr_brk = 1'b0; rd_pop = 1'b0; stat_rd = 1'b0;
      tick16 = 1'b0; word_len = 2'b11; trig_sel = 2'b00; fifo_on = 1'b1;
      ie_data = 1'b1;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_order();
      t_full();
      t_trig();
      t_perchar();
      t_mask();
      t_empty_pop();
      for (int wl = 0; wl < 4; wl++) t_timeout(wl);
      t_restart();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule